// File: doc/BRIEF.md
# System Peripheral Space Decoder with Secure Alias

This block sits between a processor's private peripheral port and the handful of register targets that live in the 1 MB system space at 0xE0000000. Every request carries a privilege bit and a security bit. The block decodes the address combinationally and raises exactly one select strobe toward the system-register target, the secure timer bank, the non-secure timer bank or the error-reporting block. Alongside the strobe it forwards the page offset, the write data, the size, the privilege and the security attribute that the target is to use.

Regions overlap, and a fixed priority picks the winner. The timer window and the error-reporting block rank highest, the 4 KB system-register page ranks next, and a default fill covers the rest of the space. The default fill reads as zero and ignores writes for privileged requests, and faults unprivileged ones. A second 4 KB page forwards secure requests to the same targets with the security attribute cleared. Non-secure requests to that page get the default fill. The response, with read data and an error flag, is registered and appears one cycle after the request.

Two compile-time switches select the variant. One includes the security extension; the other includes the error-reporting block. Target register contents are outside the block: the targets are stub ports.

Top module: `ppb_decoder`

## Requirements
- R1: After reset, rspValid, rspErr and rspRdata are 0, and no select strobe is high while reqValid is low.
- R2: A request presented with reqValid high in one cycle gets rspValid high for exactly the next cycle, with its rspRdata and rspErr. At most one select strobe is high at any time, and strobes are low while reqValid is low.
- R3: Addresses 0xE000E000 to 0xE000EFFF outside the timer window raise sysSel. tgtOffset equals reqAddr[11:0], tgtSecure equals reqSecure, and a read returns sysRdata with rspErr 0.
- R4: The timer window 0xE000E010 to 0xE000E0EF takes priority over the system-register page. A secure request raises tmrSSel and returns tmrSRdata; a non-secure one raises tmrNsSel and returns tmrNsRdata. Privilege does not change the routing.
- R5: With the error-reporting block enabled, 0xE0005000 to 0xE0005FFF raises errBlkSel and returns errBlkRdata. With it disabled, that page behaves as the default fill.
- R6: Any other address in 0xE0000000 to 0xE00FFFFF raises no strobe. A privileged request gets rspRdata 0 and rspErr 0; an unprivileged one gets rspErr 1 and rspRdata 0.
- R7: reqSize encodes log2 of the byte count (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8). The default fill answers all four codes the same way, and tgtSize forwards the code to the selected target.
- R8: With the security extension, a secure request to the alias page 0xE002E000 to 0xE002EFFF is routed as if it were to 0xE000E000 plus the same offset, with tgtSecure 0. Its timer part, 0xE002E010 to 0xE002E0EF, always selects the non-secure bank.
- R9: A non-secure request to the alias page raises no strobe and gets the default fill response of R6.
- R10: Without the security extension, reqSecure is treated as 0. tmrSSel never rises, tgtSecure stays 0, and the alias page always gets the default fill.
- R11: A write returns rspRdata 0. For a selected target, tgtWrite, tgtWdata and tgtPriv carry the request's values.
- R12: A request whose address lies outside 0xE0000000 to 0xE00FFFFF raises no strobe and gets rspErr 1 whatever its privilege.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 32 | Byte address of the request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | log2 of access byte count |
| reqWdata | input | DATA_W | Write data |
| reqPriv | input | 1 | Request is privileged |
| reqSecure | input | 1 | Request is secure |
| sysSel | output | 1 | Select system-register target |
| tmrSSel | output | 1 | Select secure timer bank |
| tmrNsSel | output | 1 | Select non-secure timer bank |
| errBlkSel | output | 1 | Select error-reporting block |
| tgtOffset | output | 12 | Offset within the 4 KB page |
| tgtWrite | output | 1 | Forwarded write flag |
| tgtSize | output | 2 | Forwarded size code |
| tgtWdata | output | DATA_W | Forwarded write data |
| tgtPriv | output | 1 | Forwarded privilege |
| tgtSecure | output | 1 | Security attribute the target uses |
| sysRdata | input | DATA_W | Read data from system-register target |
| tmrSRdata | input | DATA_W | Read data from secure timer bank |
| tmrNsRdata | input | DATA_W | Read data from non-secure timer bank |
| errBlkRdata | input | DATA_W | Read data from error-reporting block |
| rspValid | output | 1 | Response valid |
| rspRdata | output | DATA_W | Response read data |
| rspErr | output | 1 | Response bus error |

## Verification
Addresses are chosen on both sides of every region edge: just below and at the first and last byte of the timer window, the last word of the system page, and the pages beside the error block. A routing mistake at a boundary therefore shows up as the wrong strobe or the wrong read data. Each region is probed with all four combinations of privilege and security. This separates routing driven by security (timer bank choice, alias forwarding) from responses driven by privilege (default fill versus fault). The alias page is compared against the main page with the same offsets, and a second instance built without the security extension and without the error block is run over the same addresses to show how the variants differ.

// File: rtl/ppb_pkg.sv
`timescale 1ns/1ps
package ppb_pkg;
  localparam int ADDR_W  = 32;
  localparam int SPACE_W = 20;                 // 1 MB decoded space
  localparam int OFFS_W  = 12;                 // 4 KB page
  localparam int TAG_W   = ADDR_W - SPACE_W;
  localparam int PAGE_W  = SPACE_W - OFFS_W;

  localparam logic [TAG_W-1:0]  SPACE_TAG = 12'hE00;
  localparam logic [PAGE_W-1:0] PG_SYS    = 8'h0E;
  localparam logic [PAGE_W-1:0] PG_ALIAS  = 8'h2E;
  localparam logic [PAGE_W-1:0] PG_ERR    = 8'h05;
  localparam logic [OFFS_W-1:0] TMR_FIRST = 12'h010;
  localparam logic [OFFS_W-1:0] TMR_LAST  = 12'h0EF;

  // strobes from the decoder to the response datapath
  typedef struct packed {
    logic selSys;
    logic selTmrS;
    logic selTmrNs;
    logic selErrBlk;
    logic fillDefault;
    logic outside;
    logic fwdSecure;
  } ppb_strb_t;
endpackage

// File: rtl/ppb_decode.sv
`timescale 1ns/1ps
module ppb_decode
  import ppb_pkg::*;
#(
  parameter bit SEC_EXT   = 1'b1,
  parameter bit ERRBLK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSecure,
  output ppb_strb_t         strb
);
  logic [TAG_W-1:0]  addrTag;
  logic [PAGE_W-1:0] addrPage;
  logic [OFFS_W-1:0] addrOffs;
  logic inSpace, effSecure, mainPage, aliasPage, errPage;
  logic tmrOffs, aliasFwd, regPage, tmrHit, sysHit, bankSecure;

  assign addrTag  = reqAddr[ADDR_W-1:SPACE_W];
  assign addrPage = reqAddr[SPACE_W-1:OFFS_W];
  assign addrOffs = reqAddr[OFFS_W-1:0];

  assign inSpace   = (addrTag == SPACE_TAG);
  assign effSecure = SEC_EXT & reqSecure;
  assign mainPage  = (addrPage == PG_SYS);
  assign aliasPage = (addrPage == PG_ALIAS);

  generate
    if (ERRBLK_EN) begin : g_errBlk
      assign errPage = (addrPage == PG_ERR);
    end else begin : g_noErrBlk
      assign errPage = 1'b0;
    end
  endgenerate

  // timer window outranks the system page it sits inside
  assign tmrOffs    = (addrOffs >= TMR_FIRST) && (addrOffs <= TMR_LAST);
  assign aliasFwd   = aliasPage & effSecure;
  assign regPage    = mainPage | aliasFwd;
  assign tmrHit     = regPage & tmrOffs;
  assign sysHit     = regPage & ~tmrOffs;
  assign bankSecure = mainPage & effSecure;

  always_comb begin
    strb = '0;
    if (reqValid) begin
      if (!inSpace) begin
        strb.outside = 1'b1;
      end else begin
        strb.selTmrS     = tmrHit & bankSecure;
        strb.selTmrNs    = tmrHit & ~bankSecure;
        strb.selSys      = sysHit;
        strb.selErrBlk   = errPage;
        strb.fillDefault = ~(tmrHit | sysHit | errPage);
        strb.fwdSecure   = effSecure & ~aliasPage;
      end
    end
  end

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selSys, strb.selTmrS, strb.selTmrNs, strb.selErrBlk,
              strb.fillDefault, strb.outside})) else $error("route"); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(strb.selSys | strb.selTmrS | strb.selTmrNs | strb.selErrBlk))
    else $error("idle strobe"); // R2
  AST_SBANK_SECURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.selTmrS |-> (reqSecure && addrPage == PG_SYS)) else $error("s bank"); // R4
  AST_ALIAS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && inSpace && aliasPage) |-> !strb.fwdSecure) else $error("alias sec"); // R8
endmodule

// File: rtl/ppb_resp.sv
`timescale 1ns/1ps
module ppb_resp
  import ppb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqPriv,
  input  ppb_strb_t         strb,
  input  logic [DATA_W-1:0] sysRdata,
  input  logic [DATA_W-1:0] tmrSRdata,
  input  logic [DATA_W-1:0] tmrNsRdata,
  input  logic [DATA_W-1:0] errBlkRdata,
  output logic              sysSel,
  output logic              tmrSSel,
  output logic              tmrNsSel,
  output logic              errBlkSel,
  output logic              tgtSecure,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr
);
  logic [DATA_W-1:0] muxData;
  logic              errNext;

  assign sysSel    = strb.selSys;
  assign tmrSSel   = strb.selTmrS;
  assign tmrNsSel  = strb.selTmrNs;
  assign errBlkSel = strb.selErrBlk;
  assign tgtSecure = strb.fwdSecure;

  // strobes are one-hot, so an AND-OR mux suffices; default fill reads 0
  always_comb begin
    muxData = ({DATA_W{strb.selSys}}    & sysRdata)
            | ({DATA_W{strb.selTmrS}}   & tmrSRdata)
            | ({DATA_W{strb.selTmrNs}}  & tmrNsRdata)
            | ({DATA_W{strb.selErrBlk}} & errBlkRdata);
    if (reqWrite) muxData = '0;
    errNext = strb.outside | (strb.fillDefault & ~reqPriv);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspRdata <= muxData;
      rspErr   <= errNext;
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid) else $error("no rsp"); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid) else $error("stray rsp"); // R2
  AST_WRITE_RAZ: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> (rspRdata == '0)) else $error("write data"); // R11
  AST_FILL_PRIV: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && strb.fillDefault && reqPriv) |=> (!rspErr && rspRdata == '0))
    else $error("fill priv"); // R6
  AST_OUTSIDE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && strb.outside) |=> rspErr) else $error("outside"); // R12
endmodule

// File: rtl/ppb_decoder.sv
`timescale 1ns/1ps
module ppb_decoder
  import ppb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter bit SEC_EXT   = 1'b1,
  parameter bit ERRBLK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [31:0]       reqAddr,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqPriv,
  input  logic              reqSecure,
  output logic              sysSel,
  output logic              tmrSSel,
  output logic              tmrNsSel,
  output logic              errBlkSel,
  output logic [11:0]       tgtOffset,
  output logic              tgtWrite,
  output logic [1:0]        tgtSize,
  output logic [DATA_W-1:0] tgtWdata,
  output logic              tgtPriv,
  output logic              tgtSecure,
  input  logic [DATA_W-1:0] sysRdata,
  input  logic [DATA_W-1:0] tmrSRdata,
  input  logic [DATA_W-1:0] tmrNsRdata,
  input  logic [DATA_W-1:0] errBlkRdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr
);
  ppb_strb_t strb;

  assign tgtOffset = reqAddr[OFFS_W-1:0];
  assign tgtWrite  = reqWrite;
  assign tgtSize   = reqSize;
  assign tgtWdata  = reqWdata;
  assign tgtPriv   = reqPriv;

  ppb_decode #(.SEC_EXT(SEC_EXT), .ERRBLK_EN(ERRBLK_EN)) decode_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSecure(reqSecure), .strb(strb)
  );

  ppb_resp #(.DATA_W(DATA_W)) resp_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPriv(reqPriv), .strb(strb),
    .sysRdata(sysRdata), .tmrSRdata(tmrSRdata), .tmrNsRdata(tmrNsRdata),
    .errBlkRdata(errBlkRdata),
    .sysSel(sysSel), .tmrSSel(tmrSSel), .tmrNsSel(tmrNsSel), .errBlkSel(errBlkSel),
    .tgtSecure(tgtSecure), .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr)
  );
endmodule

// File: tb/ppb_decoder_tb_top.sv
`timescale 1ns/1ps
module ppb_decoder_tb_top;
  localparam logic [31:0] D_SYS = 32'h5150_0001;
  localparam logic [31:0] D_TS  = 32'h7A11_0002;
  localparam logic [31:0] D_TN  = 32'h7B22_0003;
  localparam logic [31:0] D_ERR = 32'h0E44_0004;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqPriv = 1'b0, reqSecure = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [1:0] reqSize = '0;

  logic sysSel, tmrSSel, tmrNsSel, errBlkSel, tgtWrite, tgtPriv, tgtSecure;
  logic [11:0] tgtOffset;
  logic [1:0] tgtSize;
  logic [31:0] tgtWdata, rspRdata;
  logic rspValid, rspErr;

  logic nSysSel, nTmrSSel, nTmrNsSel, nErrBlkSel, nTgtWrite, nTgtPriv, nTgtSecure;
  logic [11:0] nTgtOffset;
  logic [1:0] nTgtSize;
  logic [31:0] nTgtWdata, nRspRdata;
  logic nRspValid, nRspErr;

  int nChecks = 0;
  int nErrors = 0;

  always #2.5 clk = ~clk;

  ppb_decoder dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqWdata(reqWdata), .reqPriv(reqPriv), .reqSecure(reqSecure),
    .sysSel(sysSel), .tmrSSel(tmrSSel), .tmrNsSel(tmrNsSel), .errBlkSel(errBlkSel),
    .tgtOffset(tgtOffset), .tgtWrite(tgtWrite), .tgtSize(tgtSize), .tgtWdata(tgtWdata),
    .tgtPriv(tgtPriv), .tgtSecure(tgtSecure),
    .sysRdata(D_SYS), .tmrSRdata(D_TS), .tmrNsRdata(D_TN), .errBlkRdata(D_ERR),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr)
  );

  ppb_decoder #(.SEC_EXT(1'b0), .ERRBLK_EN(1'b0)) dutNoSec_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqWdata(reqWdata), .reqPriv(reqPriv), .reqSecure(reqSecure),
    .sysSel(nSysSel), .tmrSSel(nTmrSSel), .tmrNsSel(nTmrNsSel), .errBlkSel(nErrBlkSel),
    .tgtOffset(nTgtOffset), .tgtWrite(nTgtWrite), .tgtSize(nTgtSize), .tgtWdata(nTgtWdata),
    .tgtPriv(nTgtPriv), .tgtSecure(nTgtSecure),
    .sysRdata(D_SYS), .tmrSRdata(D_TS), .tmrNsRdata(D_TN), .errBlkRdata(D_ERR),
    .rspValid(nRspValid), .rspRdata(nRspRdata), .rspErr(nRspErr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request; expSel order {sys, tmrS, tmrNs, errBlk}
  task automatic access(input string tag, input logic [31:0] addr, input logic wr,
                        input logic [1:0] sz, input logic priv, input logic sec,
                        input logic [3:0] expSel, input logic expFwd,
                        input logic [31:0] expData, input logic expErr);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqWrite = wr; reqSize = sz;
    reqPriv = priv; reqSecure = sec; reqWdata = 32'hA5A5_0000 ^ addr;
    #1;
    check({tag, " sel"}, {28'd0, sysSel, tmrSSel, tmrNsSel, errBlkSel}, {28'd0, expSel});
    if (expSel != 4'd0) begin
      check({tag, " tgtSecure"}, {31'd0, tgtSecure}, {31'd0, expFwd});
      check({tag, " tgtOffset"}, {20'd0, tgtOffset}, {20'd0, addr[11:0]});
      check({tag, " tgtWrite R11"}, {31'd0, tgtWrite}, {31'd0, wr});
      check({tag, " tgtWdata R11"}, tgtWdata, 32'hA5A5_0000 ^ addr);
      check({tag, " tgtPriv R11"}, {31'd0, tgtPriv}, {31'd0, priv});
      check({tag, " tgtSize R7"}, {30'd0, tgtSize}, {30'd0, sz});
    end
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " rspValid R2"}, {31'd0, rspValid}, 32'd1);
    check({tag, " rspRdata"}, rspRdata, expData);
    check({tag, " rspErr"}, {31'd0, rspErr}, {31'd0, expErr});
    #1;
    check({tag, " idle sel R2"}, {28'd0, sysSel, tmrSSel, tmrNsSel, errBlkSel}, 32'd0);
    @(negedge clk);
    check({tag, " rsp pulse R2"}, {31'd0, rspValid}, 32'd0);
  endtask

  // same stimulus, checked on the variant without security and error block
  task automatic accessNoSec(input string tag, input logic [31:0] addr, input logic priv,
                             input logic sec, input logic [3:0] expSel,
                             input logic [31:0] expData, input logic expErr);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqWrite = 1'b0; reqSize = 2'd2;
    reqPriv = priv; reqSecure = sec; reqWdata = '0;
    #1;
    check({tag, " sel"}, {28'd0, nSysSel, nTmrSSel, nTmrNsSel, nErrBlkSel}, {28'd0, expSel});
    check({tag, " tgtSecure"}, {31'd0, nTgtSecure}, 32'd0);
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " rspRdata"}, nRspRdata, expData);
    check({tag, " rspErr"}, {31'd0, nRspErr}, {31'd0, expErr});
  endtask

  task automatic testReset();
    #1;
    check("R1 rspValid", {31'd0, rspValid}, 32'd0);
    check("R1 rspErr", {31'd0, rspErr}, 32'd0);
    check("R1 rspRdata", rspRdata, 32'd0);
    check("R1 sel", {28'd0, sysSel, tmrSSel, tmrNsSel, errBlkSel}, 32'd0);
  endtask

  task automatic testSysRegs();
    access("R3 sys s",       32'hE000_ED04, 1'b0, 2'd2, 1'b1, 1'b1, 4'b1000, 1'b1, D_SYS, 1'b0);
    access("R3 sys ns",      32'hE000_ED04, 1'b0, 2'd2, 1'b1, 1'b0, 4'b1000, 1'b0, D_SYS, 1'b0);
    access("R3 below tmr",   32'hE000_E00C, 1'b0, 2'd2, 1'b1, 1'b0, 4'b1000, 1'b0, D_SYS, 1'b0);
    access("R3 above tmr",   32'hE000_E0F0, 1'b0, 2'd2, 1'b1, 1'b1, 4'b1000, 1'b1, D_SYS, 1'b0);
    access("R3 page end",    32'hE000_EFFC, 1'b0, 2'd2, 1'b0, 1'b0, 4'b1000, 1'b0, D_SYS, 1'b0);
  endtask

  task automatic testTimer();
    access("R4 tmr first s", 32'hE000_E010, 1'b0, 2'd2, 1'b1, 1'b1, 4'b0100, 1'b1, D_TS, 1'b0);
    access("R4 tmr last ns", 32'hE000_E0EF, 1'b0, 2'd0, 1'b1, 1'b0, 4'b0010, 1'b0, D_TN, 1'b0);
    access("R4 tmr unpriv s",32'hE000_E018, 1'b0, 2'd2, 1'b0, 1'b1, 4'b0100, 1'b1, D_TS, 1'b0);
    access("R4 tmr unpriv ns",32'hE000_E018,1'b0, 2'd2, 1'b0, 1'b0, 4'b0010, 1'b0, D_TN, 1'b0);
  endtask

  task automatic testErrBlk();
    access("R5 err first",   32'hE000_5000, 1'b0, 2'd2, 1'b1, 1'b1, 4'b0001, 1'b1, D_ERR, 1'b0);
    access("R5 err last",    32'hE000_5FFC, 1'b0, 2'd2, 1'b0, 1'b0, 4'b0001, 1'b0, D_ERR, 1'b0);
    access("R5 err beyond",  32'hE000_6000, 1'b0, 2'd2, 1'b0, 1'b0, 4'b0000, 1'b0, 32'd0, 1'b1);
  endtask

  task automatic testDefault();
    access("R6 fill priv",   32'hE000_1000, 1'b0, 2'd2, 1'b1, 1'b1, 4'b0000, 1'b0, 32'd0, 1'b0);
    access("R6 fill unpriv", 32'hE000_1000, 1'b0, 2'd2, 1'b0, 1'b1, 4'b0000, 1'b0, 32'd0, 1'b1);
    access("R6 space start", 32'hE000_0000, 1'b0, 2'd2, 1'b0, 1'b0, 4'b0000, 1'b0, 32'd0, 1'b1);
    access("R6 space end",   32'hE00F_FFFC, 1'b0, 2'd2, 1'b1, 1'b0, 4'b0000, 1'b0, 32'd0, 1'b0);
    for (int s = 0; s < 4; s++) begin
      access("R7 size priv",   32'hE000_2000, 1'b0, 2'(s), 1'b1, 1'b0, 4'b0000, 1'b0, 32'd0, 1'b0);
      access("R7 size unpriv", 32'hE000_2000, 1'b1, 2'(s), 1'b0, 1'b0, 4'b0000, 1'b0, 32'd0, 1'b1);
    end
  endtask

  task automatic testAliasSecure();
    access("R8 alias sys",   32'hE002_ED00, 1'b0, 2'd2, 1'b1, 1'b1, 4'b1000, 1'b0, D_SYS, 1'b0);
    access("R8 alias tmr lo",32'hE002_E010, 1'b0, 2'd2, 1'b1, 1'b1, 4'b0010, 1'b0, D_TN, 1'b0);
    access("R8 alias tmr hi",32'hE002_E0EF, 1'b0, 2'd0, 1'b0, 1'b1, 4'b0010, 1'b0, D_TN, 1'b0);
    access("R8 alias below", 32'hE002_E00C, 1'b0, 2'd2, 1'b1, 1'b1, 4'b1000, 1'b0, D_SYS, 1'b0);
  endtask

  task automatic testAliasNonSecure();
    access("R9 alias ns priv",   32'hE002_ED00, 1'b0, 2'd2, 1'b1, 1'b0, 4'b0000, 1'b0, 32'd0, 1'b0);
    access("R9 alias ns unpriv", 32'hE002_E010, 1'b0, 2'd2, 1'b0, 1'b0, 4'b0000, 1'b0, 32'd0, 1'b1);
    access("R9 alias ns write",  32'hE002_ED00, 1'b1, 2'd2, 1'b1, 1'b0, 4'b0000, 1'b0, 32'd0, 1'b0);
  endtask

  task automatic testWrite();
    access("R11 write sys",  32'hE000_ED08, 1'b1, 2'd2, 1'b1, 1'b1, 4'b1000, 1'b1, 32'd0, 1'b0);
    access("R11 write tmr",  32'hE000_E014, 1'b1, 2'd1, 1'b0, 1'b0, 4'b0010, 1'b0, 32'd0, 1'b0);
  endtask

  task automatic testOutside();
    access("R12 above space",32'hE010_0000, 1'b0, 2'd2, 1'b1, 1'b1, 4'b0000, 1'b0, 32'd0, 1'b1);
    access("R12 other tag",  32'hD000_E010, 1'b0, 2'd2, 1'b1, 1'b0, 4'b0000, 1'b0, 32'd0, 1'b1);
  endtask

  task automatic testNoSecurity();
    accessNoSec("R10 tmr s",        32'hE000_E010, 1'b1, 1'b1, 4'b0010, D_TN, 1'b0);
    accessNoSec("R10 sys s",        32'hE000_ED00, 1'b1, 1'b1, 4'b1000, D_SYS, 1'b0);
    accessNoSec("R10 alias priv",   32'hE002_ED00, 1'b1, 1'b1, 4'b0000, 32'd0, 1'b0);
    accessNoSec("R10 alias unpriv", 32'hE002_E010, 1'b0, 1'b1, 4'b0000, 32'd0, 1'b1);
    accessNoSec("R5 err disabled",  32'hE000_5000, 1'b0, 1'b0, 4'b0000, 32'd0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testSysRegs();
    testTimer();
    testErrBlk();
    testDefault();
    testAliasSecure();
    testAliasNonSecure();
    testWrite();
    testOutside();
    testNoSecurity();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule